// File: doc/BRIEF.md
# Programmable Watchdog With Reset Steering

This block is a watchdog timer for a system controller. It counts down in units of an external tick that arrives every 1/16 second. One control byte sets the timeout as a 5-bit multiplier scaled by a power of four. When the timeout expires, the block latches a flag. It then does one of two things, chosen by a steering bit in the same byte. It either emits a one-cycle interrupt pulse, or it emits a one-cycle reset request. A reset-steered timeout also clears the control byte and one bit of a neighbouring auxiliary register.

Software services the watchdog in one of two ways. It can rewrite the control byte, which clears the flag and starts a new countdown. It can also read the flag register, which restarts the countdown from the control byte already held. The system reset controller and the interrupt controller that receive the two pulses lie outside this block.

Top module: `wdog_steer`

## Requirements
- R1: After reset, the control byte (address 0x1FF7), the flag register (0x1FF0) and the auxiliary register (0x1FFC) all read 0x00, and neither output pulse is high.
- R2: The control byte holds the resolution R in bits 1:0 and the multiplier M in bits 6:2. After arming, the timeout expires on the (M × 4^R)-th tick. The resulting output pulse is high in the clock cycle right after the cycle that sampled that tick.
- R3: A bus write to the control byte stores the new value, clears flag bit 7 and restarts the countdown from the new value.
- R4: A bus read of the flag register restarts the countdown from the control byte currently held.
- R5: On expiry, bit 7 of the flag register is set. Bits 6:0 of the flag register always read 0.
- R6: If control bit 7 is 1 at expiry, the control byte becomes 0x00, auxiliary bit 6 is cleared, and `reset_req` is high for exactly one cycle. `irq_pulse` stays low.
- R7: If control bit 7 is 0 at expiry, `irq_pulse` is high for exactly one cycle, the control byte is kept, and `reset_req` stays low.
- R8: Bus writes to the flag register have no effect on it.
- R9: A multiplier of zero disables the watchdog: no expiry and no pulse, whatever the number of ticks.
- R10: After an expiry, the counter is idle and no further pulse occurs until the block is re-armed. After a reset-steered expiry, only a write re-arms it.
- R11: If a control write or a flag read falls in the same cycle as the final tick, the restart wins. No expiry occurs, and a read returns the flag as it was before that cycle.
- R12: The auxiliary register keeps only bit 6 of a write and returns it in bit 6. Its other bits read 0. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, once every 1/16 second |
| bus_addr | input | 13 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its side effect applies at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_pulse | output | 1 | One-cycle interrupt pulse on an interrupt-steered expiry |
| reset_req | output | 1 | One-cycle reset request on a reset-steered expiry |

## Verification
Two functions can collide in one clock cycle: the final tick of a countdown and a service access. The bench provokes this by arming a one-tick timeout. It then raises `tick` in the same cycle as a control write, and in a separate case in the same cycle as a flag read. The scoreboard must see no pulse in that cycle. It must then see the pulse exactly when the reloaded count runs out. In the read case, the returned flag byte must show the value from before the collision.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] AUX_ADDR  = 13'h1FFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_pulse,
  output logic              reset_req
);
  localparam int MULT_W = 5;
  localparam int CNT_W  = MULT_W + 6;

  logic [7:0]       ctrl_q;
  logic             flag_q;
  logic             aux_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] span(input logic [7:0] v);
    return CNT_W'(v[6:2]) << {v[1:0], 1'b0};
  endfunction

  wire wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
  wire wr_aux  = bus_wr && (bus_addr == AUX_ADDR);
  wire rd_flag = bus_rd && (bus_addr == FLAG_ADDR);
  wire running = tick && (cnt_q != '0);
  wire expire  = running && (cnt_q == CNT_W'(1)) && !wr_ctrl && !rd_flag;

  always_comb begin
    case (bus_addr)
      CTRL_ADDR: bus_rdata = ctrl_q;
      FLAG_ADDR: bus_rdata = {flag_q, 7'b0};
      AUX_ADDR:  bus_rdata = {1'b0, aux_q, 6'b0};
      default:   bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      aux_q     <= 1'b0;
      cnt_q     <= '0;
      irq_pulse <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      reset_req <= 1'b0;
      if (wr_aux) aux_q <= bus_wdata[6];
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata;
        flag_q <= 1'b0;
        cnt_q  <= span(bus_wdata);
      end else if (rd_flag) begin
        cnt_q <= span(ctrl_q);
      end else if (running) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (expire) begin
        flag_q <= 1'b1;
        if (ctrl_q[7]) begin
          ctrl_q    <= '0;
          aux_q     <= 1'b0;
          reset_req <= 1'b1;
        end else begin
          irq_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              irq_pulse,
  input logic              reset_req,
  input logic              flag_q,
  input logic [7:0]        ctrl_q
);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_rst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (ctrl_q == 8'h00 && flag_q));
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && reset_req));
  assert_fire_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag_q);
  assert_fire_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || reset_req) |-> $past(tick));
  assert_flag_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == FLAG_ADDR && !tick) |=> flag_q == $past(flag_q));
  assert_wr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR) |=> !flag_q);
endmodule

bind wdog_steer wdog_steer_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .irq_pulse(irq_pulse), .reset_req(reset_req), .flag_q(flag_q), .ctrl_q(ctrl_q)
);

// File: tb/test_wdog_steer.sv
module test_wdog_steer;
  localparam logic [12:0] A_CTRL = 13'h1FF7;
  localparam logic [12:0] A_FLAG = 13'h1FF0;
  localparam logic [12:0] A_AUX  = 13'h1FFC;
  localparam int K_IRQ = 1;
  localparam int K_RST = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq_pulse, reset_req;

  int total = 0, bad = 0, ncyc = 0;
  int exp_kind[$];
  int exp_cyc[$];
  string exp_tag[$];

  wdog_steer i_wdog_steer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .reset_req(reset_req)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    ncyc++;
    if (irq_pulse || reset_req) begin
      if (exp_kind.size() == 0) begin
        check(0, "R10 unexpected pulse", {30'd0, reset_req, irq_pulse}, 0);
      end else begin
        check(exp_kind[0] == (reset_req ? K_RST : K_IRQ) && exp_cyc[0] == ncyc,
              exp_tag[0], {reset_req, irq_pulse} * 100000 + ncyc,
              exp_kind[0] * 100000 + exp_cyc[0]);
        void'(exp_kind.pop_front()); void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end
    end else if (exp_cyc.size() > 0 && exp_cyc[0] <= ncyc) begin
      check(0, exp_tag[0], 0, exp_kind[0]);
      void'(exp_kind.pop_front()); void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #5 check(bus_rdata == e, tag, bus_rdata, e);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic last_tick(input int kind, input string tag);
    @(negedge clk);
    exp_kind.push_back(kind); exp_cyc.push_back(ncyc + 1); exp_tag.push_back(tag);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    check(exp_kind.size() == 0, "R2 missing pulse at end", exp_kind.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rd(A_FLAG, 8'h00, "R1 flag");
    rd(A_AUX, 8'h00, "R1 aux");
    check(!irq_pulse && !reset_req, "R1 outputs", {irq_pulse, reset_req}, 0);
    // R2 R7: M=3 R=1 -> 12 ticks
    wr(A_CTRL, 8'h0D);
    ticks(11);
    last_tick(K_IRQ, "R7 irq after 12 ticks (R2)");
    ticks(20); // R10 idle, monitor flags any pulse
    rd(A_FLAG, 8'h80, "R5 flag set");
    rd(A_CTRL, 8'h0D, "R7 ctrl kept");
    // R4: the flag read above reloaded 12
    ticks(11);
    last_tick(K_IRQ, "R4 reload by flag read");
    // R8: writes to flag ignored
    wr(A_FLAG, 8'h00);
    rd(A_CTRL, 8'h0D, "R8 ctrl unaffected");
    ticks(12); // R8 flag read above? no - ctrl read; counter idle
    // R3
    wr(A_CTRL, 8'h0D);
    rd(A_FLAG, 8'h00, "R3 flag cleared by ctrl write");
    ticks(8);
    rd(A_FLAG, 8'h00, "R4 kick read");
    ticks(11);
    last_tick(K_IRQ, "R4 restart after partial count");
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, 8'h80, "R8 flag write ignored");
    // other patterns
    wr(A_CTRL, 8'h04);
    last_tick(K_IRQ, "R2 single tick");
    wr(A_CTRL, 8'h0A);
    ticks(31);
    last_tick(K_IRQ, "R2 32 ticks");
    wr(A_CTRL, 8'h7F);
    ticks(1983);
    last_tick(K_IRQ, "R2 max 1984 ticks");
    // R6 reset steering
    wr(A_AUX, 8'hFF);
    rd(A_AUX, 8'h40, "R12 aux bit6 only");
    wr(A_CTRL, 8'h94);
    ticks(4);
    last_tick(K_RST, "R6 reset after 5 ticks");
    rd(A_CTRL, 8'h00, "R6 ctrl cleared");
    rd(A_AUX, 8'h00, "R6 aux bit cleared");
    rd(A_FLAG, 8'h80, "R6 flag set");
    ticks(30); // R10 idle after reset-steered expiry
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, 8'h80, "R8 flag write ignored after reset");
    // R9
    wr(A_CTRL, 8'h03);
    ticks(60);
    rd(A_FLAG, 8'h00, "R9 zero multiplier no expiry");
    wr(A_CTRL, 8'h80);
    ticks(20);
    rd(A_FLAG, 8'h00, "R9 zero multiplier steered");
    // R11 write collides with final tick
    wr(A_CTRL, 8'h04);
    @(negedge clk); bus_addr = A_CTRL; bus_wdata = 8'h08; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    ticks(1);
    last_tick(K_IRQ, "R11 write wins over final tick");
    // R11 read collides with final tick
    wr(A_CTRL, 8'h04);
    @(negedge clk); bus_addr = A_FLAG; bus_rd = 1'b1; tick = 1'b1;
    #5 check(bus_rdata == 8'h00, "R11 read value before collision", bus_rdata, 8'h00);
    @(negedge clk); bus_rd = 1'b0; tick = 1'b0;
    last_tick(K_IRQ, "R11 read wins over final tick");
    rd(13'h0000, 8'h00, "R12 unmapped read");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule